// File: doc/BRIEF.md
# Digital Microphone PDM Capture Front End

This block generates the bit clock for external pulse-density-modulated (PDM) digital microphones and captures their one-bit data streams. It runs from a 24 MHz system clock and derives a microphone clock of 1.5 MHz, 2.0 MHz or 3.0 MHz by dividing the system clock by 16, 12 or 8. Every rate has an exact 50/50 duty cycle. The outputs are a left and a right one-bit stream, each with a single-cycle valid strobe. These streams feed a decimation filter that is outside this block.

Two wiring layouts are supported. In the per-pin layout, each of two data pins carries one microphone. The first pin is microphone 1 (left) and the second pin is microphone 2 (right). In the shared-pin layout, both microphones drive the first data pin. The left bit is taken in the low half of the clock and the right bit in the high half. The two bits are delivered together as one pair. A power-down input parks the microphone clock low. Rate and layout changes are applied only where they cannot cut a clock pulse short or split a left/right pair.

Top module: `pdm_mic_frontend`

## Requirements
- R1: `rate_sel` picks the microphone clock period in system cycles: code 0 gives 16 (1.5 MHz), code 1 gives 12 (2.0 MHz), and codes 2 and 3 give 8 (3.0 MHz).
- R2: At every rate, `mic_clk` stays high for exactly half the period and low for exactly half the period.
- R3: While `pwr_dn` is 1, `mic_clk` makes no transitions. If `mic_clk` is low, it is held low at once. If it is high, it finishes its high half and then stays low. After `pwr_dn` returns to 0, a full-length low half comes before the first rising edge.
- R4: A new `rate_sel` or `mux_mode` value is applied only at a rising edge of `mic_clk`, which ends a low half, or at any cycle while the clock is parked. A change during a high half therefore leaves the current high and low halves at the old length.
- R5: Per-pin layout (`mux_mode`=0). `pdm_a` feeds the left stream and `pdm_b` feeds the right stream. Both pins are sampled together once per microphone clock period, before the rising edge. The valid strobe of each enabled channel pulses once per period.
- R6: Shared-pin layout (`mux_mode`=1). `pdm_a` is sampled before the rising edge as the left bit and before the falling edge as the right bit. Both are emitted together, with their strobes, before that falling edge.
- R7: `mic_en[0]` enables the left channel and `mic_en[1]` enables the right channel. A disabled channel never raises its valid strobe, and from the next cycle on its data output reads 0.
- R8: When a rate or layout change is applied, any left bit captured but not yet paired is dropped. No pair is emitted in the high half that follows the change.
- R9: Each valid strobe is high for exactly one system cycle. That cycle is the one just before the `mic_clk` edge it belongs to, so the edge follows on the next system clock. The data is the pin value seen at the same system clock edge that raised the strobe.
- R10: During reset and for two system cycles after `rst_n` rises, `mic_clk`, both strobes and both data outputs are 0. The rate comes up as code 0 and the layout as per-pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 24 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 2 | Microphone clock rate code |
| mux_mode | input | 1 | 0 = one microphone per pin, 1 = two microphones on `pdm_a` |
| mic_en | input | 2 | Channel enables, bit 0 left, bit 1 right |
| pwr_dn | input | 1 | Stops the microphone clock |
| pdm_a | input | 1 | First data pin (microphone 1, or both in shared mode) |
| pdm_b | input | 1 | Second data pin (microphone 2 in per-pin mode) |
| mic_clk | output | 1 | Clock to the microphones |
| left_bit | output | 1 | Left PDM bit |
| left_vld | output | 1 | Left bit strobe |
| right_bit | output | 1 | Right PDM bit |
| right_vld | output | 1 | Right bit strobe |

## Verification
A corrupted half-period counter or a wrongly loaded rate shows up as a `mic_clk` transition that is misplaced by at least one system cycle. This is visible within one half period, eight system cycles at most. A wrong pairing flag or a stale held left bit shows up either as a strobe in the high half that follows a configuration change or as a swapped left/right value. This is visible at the next falling edge. A cycle-by-cycle behavioural model in the bench compares all five outputs on every clock. This is done under directed rate, power-down and layout sequences and then under randomly mixed configurations, so any such deviation is reported in the cycle where it first reaches a port.

// File: rtl/pdm_fe_pkg.sv
package pdm_fe_pkg;
  localparam int HALF_W    = 4;
  localparam int NUM_LANES = 2;
  localparam int LANE_L    = 0;
  localparam int LANE_R    = 1;

  typedef logic [HALF_W-1:0] half_t;

  typedef enum logic {
    CAP_UNI = 1'b0,
    CAP_MUX = 1'b1
  } cap_mode_e;

  typedef struct packed {
    half_t     half;
    cap_mode_e mode;
  } cap_cfg_t;
endpackage

// File: rtl/pdm_rst_sync.sv
module pdm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_core_n = sync_q[STAGES-1];
endmodule

// File: rtl/pdm_clk_gen.sv
module pdm_clk_gen
  import pdm_fe_pkg::*;
#(
  parameter int HALF_SLOW = 8,
  parameter int HALF_MID  = 6,
  parameter int HALF_FAST = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic [1:0] rate_sel,
  input  logic      mux_sel,
  input  logic      pwr_dn,
  output logic      mic_clk,
  output logic      smp_lo,
  output logic      smp_hi,
  output logic      cfg_chg,
  output logic      running,
  output cap_mode_e mode_act
);
  localparam half_t H_S = half_t'(HALF_SLOW);
  localparam half_t H_M = half_t'(HALF_MID);
  localparam half_t H_F = half_t'(HALF_FAST);

  half_t    cnt_q, cnt_d;
  logic     clk_q, clk_d;
  cap_cfg_t cfg_q, cfg_req;
  logic     run, half_end, smp_pt, load;

  // requested configuration decoded from the inputs
  always_comb begin
    case (rate_sel)
      2'd0:    cfg_req.half = H_S;
      2'd1:    cfg_req.half = H_M;
      default: cfg_req.half = H_F;
    endcase
    cfg_req.mode = mux_sel ? CAP_MUX : CAP_UNI;
  end

  // next state of the half-period counter and the clock level
  always_comb begin
    run      = !(pwr_dn && !clk_q);
    half_end = (cnt_q == cfg_q.half - half_t'(1));
    smp_pt   = (cnt_q == cfg_q.half - half_t'(2));
    load     = !run || (half_end && !clk_q);
    cnt_d    = cnt_q;
    clk_d    = clk_q;
    if (!run) begin
      cnt_d = '0;
      clk_d = 1'b0;
    end else if (half_end) begin
      cnt_d = '0;
      clk_d = !clk_q;
    end else begin
      cnt_d = cnt_q + half_t'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      clk_q <= clk_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '{half: H_S, mode: CAP_UNI};
    end else if (load) begin
      cfg_q <= cfg_req;
    end
  end

  assign cfg_chg  = load && (cfg_req != cfg_q);
  assign smp_lo   = run && smp_pt && !clk_q;
  assign smp_hi   = run && smp_pt && clk_q;
  assign running  = run;
  assign mic_clk  = clk_q;
  assign mode_act = cfg_q.mode;
endmodule

// File: rtl/pdm_capture.sv
module pdm_capture
  import pdm_fe_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_lo,
  input  logic                 smp_hi,
  input  logic                 clr,
  input  cap_mode_e            mode,
  input  logic                 pin_a,
  input  logic                 pin_b,
  output logic [NUM_LANES-1:0] emit,
  output logic [NUM_LANES-1:0] val
);
  logic hold_q, hold_d, hold_en;
  logic pend_q, pend_d;

  always_comb begin
    hold_en = (mode == CAP_MUX) && smp_lo;
    hold_d  = pin_a;
    pend_d  = pend_q;
    if (clr) begin
      pend_d = 1'b0;
    end else if (hold_en) begin
      pend_d = 1'b1;
    end else if (smp_hi) begin
      pend_d = 1'b0;
    end
  end

  always_comb begin
    if (mode == CAP_UNI) begin
      emit[LANE_L] = smp_lo;
      emit[LANE_R] = smp_lo;
      val[LANE_L]  = pin_a;
      val[LANE_R]  = pin_b;
    end else begin
      emit[LANE_L] = smp_hi && pend_q;
      emit[LANE_R] = smp_hi && pend_q;
      val[LANE_L]  = hold_q;
      val[LANE_R]  = pin_a;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
    end else if (hold_en) begin
      hold_q <= hold_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/pdm_lane.sv
module pdm_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic emit,
  input  logic val,
  input  logic en,
  output logic bit_o,
  output logic vld_o
);
  logic bit_q, bit_d, vld_q, vld_d;

  always_comb begin
    vld_d = emit && en;
    if (!en) begin
      bit_d = 1'b0;
    end else if (emit) begin
      bit_d = val;
    end else begin
      bit_d = bit_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      bit_q <= bit_d;
      vld_q <= vld_d;
    end
  end

  assign bit_o = bit_q;
  assign vld_o = vld_q;
endmodule

// File: rtl/pdm_mic_frontend.sv
module pdm_mic_frontend
  import pdm_fe_pkg::*;
#(
  parameter int HALF_SLOW = 8,
  parameter int HALF_MID  = 6,
  parameter int HALF_FAST = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rate_sel,
  input  logic       mux_mode,
  input  logic [1:0] mic_en,
  input  logic       pwr_dn,
  input  logic       pdm_a,
  input  logic       pdm_b,
  output logic       mic_clk,
  output logic       left_bit,
  output logic       left_vld,
  output logic       right_bit,
  output logic       right_vld
);
  logic                 rst_core_n;
  logic                 smp_lo, smp_hi, cfg_chg, running;
  cap_mode_e            mode_act;
  logic [NUM_LANES-1:0] emit, val, lane_bit, lane_vld;

  pdm_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  pdm_clk_gen #(
    .HALF_SLOW (HALF_SLOW),
    .HALF_MID  (HALF_MID),
    .HALF_FAST (HALF_FAST)
  ) u_clk (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .rate_sel (rate_sel),
    .mux_sel  (mux_mode),
    .pwr_dn   (pwr_dn),
    .mic_clk  (mic_clk),
    .smp_lo   (smp_lo),
    .smp_hi   (smp_hi),
    .cfg_chg  (cfg_chg),
    .running  (running),
    .mode_act (mode_act)
  );

  pdm_capture u_cap (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .smp_lo (smp_lo),
    .smp_hi (smp_hi),
    .clr    (cfg_chg || !running),
    .mode   (mode_act),
    .pin_a  (pdm_a),
    .pin_b  (pdm_b),
    .emit   (emit),
    .val    (val)
  );

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    pdm_lane u_lane (
      .clk   (clk),
      .rst_n (rst_core_n),
      .emit  (emit[i]),
      .val   (val[i]),
      .en    (mic_en[i]),
      .bit_o (lane_bit[i]),
      .vld_o (lane_vld[i])
    );
  end

  assign left_bit  = lane_bit[LANE_L];
  assign left_vld  = lane_vld[LANE_L];
  assign right_bit = lane_bit[LANE_R];
  assign right_vld = lane_vld[LANE_R];
endmodule

// File: rtl/pdm_mic_chk.sv
module pdm_mic_chk
  import pdm_fe_pkg::*;
#(
  parameter int HALF_SLOW = 8,
  parameter int HALF_MID  = 6,
  parameter int HALF_FAST = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_dn,
  input logic [1:0] mic_en,
  input logic       mic_clk,
  input logic       left_vld,
  input logic       right_vld,
  input cap_mode_e  mode_act
);
  half_t hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
    end else if (mic_clk) begin
      hi_cnt <= hi_cnt + half_t'(1);
    end else begin
      hi_cnt <= '0;
    end
  end

  // R2
  high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mic_clk) |-> (hi_cnt == half_t'(HALF_SLOW) || hi_cnt == half_t'(HALF_MID) ||
                        hi_cnt == half_t'(HALF_FAST)));

  // R3
  park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_dn && !mic_clk) |=> !mic_clk);

  // R9
  strobe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((left_vld || right_vld) && !pwr_dn) |=> !$stable(mic_clk));

  // R5
  uni_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((left_vld || right_vld) && mode_act == CAP_UNI && !pwr_dn) |=> mic_clk);

  // R7
  right_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    right_vld |-> $past(mic_en[1]));

  // R7
  left_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    left_vld |-> $past(mic_en[0]));

  // R9
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    left_vld |=> !left_vld);
endmodule

bind pdm_mic_frontend pdm_mic_chk #(
  .HALF_SLOW (HALF_SLOW),
  .HALF_MID  (HALF_MID),
  .HALF_FAST (HALF_FAST)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwr_dn    (pwr_dn),
  .mic_en    (mic_en),
  .mic_clk   (mic_clk),
  .left_vld  (left_vld),
  .right_vld (right_vld),
  .mode_act  (mode_act)
);

// File: tb/sim_pdm_mic_frontend.sv
`timescale 1ns/1ps
module sim_pdm_mic_frontend;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] rate_sel;
  logic       mux_mode;
  logic [1:0] mic_en;
  logic       pwr_dn;
  logic       pdm_a, pdm_b;
  logic       mic_clk, left_bit, left_vld, right_bit, right_vld;

  int  checks = 0;
  int  fails  = 0;
  int  cyc    = 0;
  bit  done   = 0;
  bit  pin_follow = 0;

  always #4 clk = ~clk;

  pdm_mic_frontend u0 (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .mux_mode(mux_mode),
    .mic_en(mic_en), .pwr_dn(pwr_dn), .pdm_a(pdm_a), .pdm_b(pdm_b),
    .mic_clk(mic_clk), .left_bit(left_bit), .left_vld(left_vld),
    .right_bit(right_bit), .right_vld(right_vld)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int half_of(input logic [1:0] r);
    return (r == 2'd0) ? 8 : (r == 2'd1) ? 6 : 4;
  endfunction

  // behavioural reference model
  int m_sync, m_cnt, m_clk, m_half, m_mode, m_pend, m_hold, m_lb, m_lv, m_rb, m_rv;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync = 0; m_cnt = 0; m_clk = 0; m_half = 8; m_mode = 0; m_pend = 0; m_hold = 0;
      m_lb = 0; m_lv = 0; m_rb = 0; m_rv = 0;
    end else if (m_sync < 2) begin
      m_sync++;
    end else begin
      bit run, smp;
      int nh, nm;
      run = !(pwr_dn && m_clk == 0);
      smp = run && (m_cnt == m_half - 2);
      m_lv = 0; m_rv = 0;
      if (!mic_en[0]) m_lb = 0;
      if (!mic_en[1]) m_rb = 0;
      if (smp && m_clk == 0) begin
        if (m_mode == 0) begin
          if (mic_en[0]) begin m_lb = pdm_a; m_lv = 1; end
          if (mic_en[1]) begin m_rb = pdm_b; m_rv = 1; end
        end else begin
          m_hold = pdm_a; m_pend = 1;
        end
      end
      if (smp && m_clk == 1 && m_mode == 1 && m_pend == 1) begin
        if (mic_en[0]) begin m_lb = m_hold; m_lv = 1; end
        if (mic_en[1]) begin m_rb = pdm_a; m_rv = 1; end
        m_pend = 0;
      end
      nh = half_of(rate_sel);
      nm = mux_mode;
      if (run && m_cnt != m_half - 1) begin
        m_cnt++;
      end else begin
        if (!run || m_clk == 0) begin
          if (nh != m_half || nm != m_mode) m_pend = 0;
          m_half = nh; m_mode = nm;
        end
        if (!run) begin m_clk = 0; m_pend = 0; end
        else m_clk = 1 - m_clk;
        m_cnt = 0;
      end
    end
  end

  // pin drive and per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (pin_follow) begin
      pdm_a <= !mic_clk;
      pdm_b <= mic_clk;
    end else begin
      pdm_a <= 1'($urandom % 2);
      pdm_b <= 1'($urandom % 2);
    end
    if (rst_n && !done) begin
      checks++;
      if (mic_clk !== 1'(m_clk)) begin
        fails++;
        $display("FAIL R2 model mic_clk actual=%0d expected=%0d", mic_clk, m_clk);
      end else if (left_vld !== 1'(m_lv) || left_bit !== 1'(m_lb)) begin
        fails++;
        $display("FAIL R5 model left vld/bit actual=%0d%0d expected=%0d%0d",
                 left_vld, left_bit, m_lv, m_lb);
      end else if (right_vld !== 1'(m_rv) || right_bit !== 1'(m_rb)) begin
        fails++;
        $display("FAIL R6 model right vld/bit actual=%0d%0d expected=%0d%0d",
                 right_vld, right_bit, m_rv, m_rb);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog R1 actual=%0d expected=finish", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic wait_lvl(input logic lvl);
    while (mic_clk == lvl) @(negedge clk);
    while (mic_clk != lvl) @(negedge clk);
  endtask

  initial begin
    int n_h, n_l, n, cv, cr;
    bit prev;
    rst_n = 0; rate_sel = 0; mux_mode = 0; mic_en = 2'b11; pwr_dn = 0;
    pdm_a = 0; pdm_b = 0;
    repeat (5) @(negedge clk);
    // R10 reset state
    chk(mic_clk == 0 && left_vld == 0 && right_vld == 0 && left_bit == 0 && right_bit == 0,
        "R10", "outputs in reset", {mic_clk, left_vld, right_vld}, 0);
    rst_n = 1;
    @(negedge clk); @(negedge clk);
    chk(mic_clk == 0 && left_vld == 0 && right_vld == 0, "R10", "outputs after release", mic_clk, 0);

    // R1 R2 each rate code
    for (int r = 0; r < 4; r++) begin
      rate_sel = 2'(r);
      wait_lvl(1); wait_lvl(1);
      n_h = 0; while (mic_clk) begin n_h++; @(negedge clk); end
      n_l = 0; while (!mic_clk) begin n_l++; @(negedge clk); end
      chk(n_h == half_of(2'(r)) && n_l == half_of(2'(r)), "R2", "high/low half length", n_h * 100 + n_l,
          half_of(2'(r)) * 101);
      chk(n_h + n_l == 2 * half_of(2'(r)), "R1", "period in system cycles", n_h + n_l, 2 * half_of(2'(r)));
    end

    // R4 change during a high half
    rate_sel = 0;
    wait_lvl(1); wait_lvl(1);
    n = 0; repeat (2) begin n++; @(negedge clk); end
    rate_sel = 2;
    while (mic_clk) begin n++; @(negedge clk); end
    chk(n == 8, "R4", "high half keeps old length", n, 8);
    n = 0; while (!mic_clk) begin n++; @(negedge clk); end
    chk(n == 8, "R4", "low half keeps old length", n, 8);
    n = 0; while (mic_clk) begin n++; @(negedge clk); end
    chk(n == 4, "R4", "new length after rise", n, 4);

    // R5 R9 per-pin layout, left pin 1 / right pin 0 in the low half
    rate_sel = 1; pin_follow = 1;
    wait_lvl(1); wait_lvl(1);
    cv = 0; prev = 0;
    for (int i = 0; i < 48; i++) begin
      if (prev) chk(mic_clk == 1, "R9", "rise follows strobe", mic_clk, 1);
      if (left_vld) begin
        cv++;
        chk(left_bit == 1 && right_vld == 1 && right_bit == 0, "R5", "per-pin values",
            {left_bit, right_vld, right_bit}, 3'b110);
      end
      prev = left_vld;
      @(negedge clk);
    end
    chk(cv == 4, "R5", "strobes per 4 periods", cv, 4);

    // R6 shared-pin layout
    mux_mode = 1;
    wait_lvl(1); wait_lvl(1);
    cv = 0; prev = 0;
    for (int i = 0; i < 48; i++) begin
      if (prev) chk(mic_clk == 0, "R9", "fall follows pair strobe", mic_clk, 0);
      if (left_vld || right_vld) begin
        cv++;
        chk(left_vld && right_vld && left_bit == 1 && right_bit == 0, "R6", "pair values",
            {left_vld, right_vld, left_bit, right_bit}, 4'b1110);
      end
      prev = left_vld;
      @(negedge clk);
    end
    chk(cv == 4, "R6", "pairs per 4 periods", cv, 4);

    // R8 change applied after a left capture drops the pair
    wait_lvl(0);
    rate_sel = 0;
    wait_lvl(1);
    cv = 0; while (mic_clk) begin cv += int'(left_vld || right_vld); @(negedge clk); end
    chk(cv == 0, "R8", "no pair after change", cv, 0);
    wait_lvl(1);
    cv = 0; while (mic_clk) begin cv += int'(left_vld && right_vld); @(negedge clk); end
    chk(cv == 1, "R8", "pairing resumes", cv, 1);

    // R7 single channel enabled
    mux_mode = 0; pin_follow = 0; mic_en = 2'b01;
    @(negedge clk);
    cv = 0; cr = 0;
    for (int i = 0; i < 64; i++) begin
      cv += int'(left_vld);
      cr += int'(right_vld || right_bit);
      @(negedge clk);
    end
    chk(cr == 0, "R7", "right disabled quiet", cr, 0);
    chk(cv > 0, "R7", "left still strobes", cv, 4);
    mic_en = 2'b10;
    @(negedge clk);
    cv = 0; cr = 0;
    for (int i = 0; i < 64; i++) begin
      cv += int'(left_vld || left_bit);
      cr += int'(right_vld);
      @(negedge clk);
    end
    chk(cv == 0, "R7", "left disabled quiet", cv, 0);
    chk(cr > 0, "R7", "right still strobes", cr, 4);

    // R3 power-down and restart
    mic_en = 2'b11; rate_sel = 2;
    repeat (20) @(negedge clk);
    pwr_dn = 1;
    repeat (12) @(negedge clk);
    rate_sel = 1;
    cv = 0;
    for (int i = 0; i < 50; i++) begin
      cv += int'(mic_clk || left_vld || right_vld);
      @(negedge clk);
    end
    chk(cv == 0, "R3", "no clock activity while parked", cv, 0);
    pwr_dn = 0;
    n = 0; while (!mic_clk) begin n++; @(negedge clk); end
    chk(n == 6, "R3", "full low half after restart", n, 6);

    // mixed random configurations under the model
    for (int k = 0; k < 60; k++) begin
      rate_sel = 2'($urandom_range(0, 3));
      mux_mode = 1'($urandom_range(0, 1));
      mic_en   = 2'($urandom_range(0, 3));
      pwr_dn   = ($urandom_range(0, 5) == 0);
      repeat ($urandom_range(10, 90)) @(negedge clk);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule